// File: doc/BRIEF.md
# Two-Level Page Table Walker

When a translation lookup misses, this block resolves a 32-bit virtual address by walking a two-level page table held in memory. The caller supplies the physical address of the root directory and the 20-bit virtual page number. The walker first reads the directory entry that the upper index selects. If that entry marks a second-level table as present, it reads the table entry that the lower index selects. It then reports the physical page number and the access flags, or a fault together with the level at which the walk stopped.

The 4 KB page offset never reaches the walker; only the page number is needed. Entries are 4 bytes wide. Each level has 1024 entries, so each index is scaled by four and added to a base address. The block handles one walk at a time. It uses a single request/response memory port that allows at most one read in flight. Loading the result into a translation cache and handling faults are left to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: The first memory read of a walk targets `req_root + 4 * req_vpn[19:10]`; the directory index corresponds to virtual address bits 31:22.
- R3: A directory entry whose bit 0 is 0 ends the walk after that single read. The result is `res_fault`=1, `res_fault_level`=1, `res_ppn`=0, `res_writable`=0, `res_user`=0.
- R4: For a directory entry with bit 0 set, the second read targets `{entry[31:12], 12'h000} + 4 * req_vpn[9:0]`. The entry's bits 11:1 do not affect the address.
- R5: A table entry whose bit 0 is 0 ends the walk with `res_fault`=1, `res_fault_level`=2, `res_ppn`=0 and both flags 0.
- R6: A table entry with bit 0 set gives `res_fault`=0 and `res_fault_level`=0. It also gives `res_ppn`=entry[31:12], `res_writable`=entry[1] and `res_user`=entry[2].
- R7: Once `mem_req_valid` is raised, it stays high with an unchanged `mem_req_addr` until a cycle in which `mem_req_ready` is 1.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the result has been presented. A `req_valid` raised during that time is ignored.
- R9: `res_valid` is high for exactly one cycle per walk. All result fields keep their values until the next walk presents its result.
- R10: No new memory read is requested while a read is still awaiting its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle; request accepted when both are high |
| req_root | input | 32 | Physical address of the root directory |
| req_vpn | input | 20 | Virtual page number (virtual address bits 31:12) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk ended in a fault |
| res_fault_level | output | 2 | 0 none, 1 directory, 2 table |
| res_ppn | output | 20 | Physical page number |
| res_writable | output | 1 | Entry write permission |
| res_user | output | 1 | Entry user-access permission |

## Verification
The bench builds the walker with its default widths: 10 directory index bits, 10 table index bits, 12 offset bits and 32-bit entries. With these values, the largest index of 1023 is reached at both levels. Entry addresses such as root + 0xFFC can therefore be checked, including a table entry at 0xFFFFFFFC at the very top of the address space. A memory model with adjustable acceptance stalls and response latency shows that the request holds steady and that reads never overlap.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    typedef enum logic [2:0] {
        WS_IDLE     = 3'd0,
        WS_READ_DIR = 3'd1,
        WS_WAIT_DIR = 3'd2,
        WS_READ_PTE = 3'd3,
        WS_WAIT_PTE = 3'd4,
        WS_DONE     = 3'd5
    } walk_state_e;

    localparam logic [1:0] FLVL_NONE = 2'd0;
    localparam logic [1:0] FLVL_DIR  = 2'd1;
    localparam logic [1:0] FLVL_TBL  = 2'd2;

    localparam int ENTRY_VALID_BIT = 0;
    localparam int ENTRY_WRITE_BIT = 1;
    localparam int ENTRY_USER_BIT  = 2;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'(idx) << SHIFT;
        addr   = base + offset;
    end
endmodule

// File: rtl/pt_walk_entry.sv
module pt_walk_entry #(
    parameter int ENTRY_W   = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic [ENTRY_W-1:0]           entry,
    output logic                         present,
    output logic                         writable,
    output logic                         user,
    output logic [ENTRY_W-PAGE_BITS-1:0] frame
);
    import pt_walk_pkg::*;

    always_comb begin
        present  = entry[ENTRY_VALID_BIT];
        writable = entry[ENTRY_WRITE_BIT];
        user     = entry[ENTRY_USER_BIT];
        frame    = entry[ENTRY_W-1:PAGE_BITS];
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int DIR_BITS  = 10,
    parameter int TBL_BITS  = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [ADDR_W-1:0]             req_root,
    input  logic [DIR_BITS+TBL_BITS-1:0]  req_vpn,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic [ADDR_W-1:0]             mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [ADDR_W-1:0]             mem_rsp_data,
    output logic                          res_valid,
    output logic                          res_fault,
    output logic [1:0]                    res_fault_level,
    output logic [ADDR_W-PAGE_BITS-1:0]   res_ppn,
    output logic                          res_writable,
    output logic                          res_user
);
    import pt_walk_pkg::*;

    localparam int VPN_W       = DIR_BITS + TBL_BITS;
    localparam int PPN_W       = ADDR_W - PAGE_BITS;
    localparam int ENTRY_BYTES = ADDR_W / 8;

    typedef struct packed {
        walk_state_e        st;
        logic [ADDR_W-1:0]  root;
        logic [VPN_W-1:0]   vpn;
        logic [ADDR_W-1:0]  tbase;
        logic [PPN_W-1:0]   ppn;
        logic               wr;
        logic               usr;
        logic               fault;
        logic [1:0]         lvl;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [DIR_BITS-1:0] dir_idx;
    logic [TBL_BITS-1:0] tbl_idx;
    logic [ADDR_W-1:0]   dir_addr;
    logic [ADDR_W-1:0]   pte_addr;
    logic                ent_present;
    logic                ent_writable;
    logic                ent_user;
    logic [PPN_W-1:0]    ent_frame;

    assign dir_idx = r_q.vpn[VPN_W-1 -: DIR_BITS];
    assign tbl_idx = r_q.vpn[TBL_BITS-1:0];

    pt_walk_addr #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (DIR_BITS),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_dir_addr (
        .base (r_q.root),
        .idx  (dir_idx),
        .addr (dir_addr)
    );

    pt_walk_addr #(
        .ADDR_W      (ADDR_W),
        .IDX_W       (TBL_BITS),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_pte_addr (
        .base (r_q.tbase),
        .idx  (tbl_idx),
        .addr (pte_addr)
    );

    pt_walk_entry #(
        .ENTRY_W   (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_entry (
        .entry    (mem_rsp_data),
        .present  (ent_present),
        .writable (ent_writable),
        .user     (ent_user),
        .frame    (ent_frame)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WS_IDLE: begin
                if (req_valid) begin
                    r_d.root = req_root;
                    r_d.vpn  = req_vpn;
                    r_d.st   = WS_READ_DIR;
                end
            end
            WS_READ_DIR: begin
                if (mem_req_ready) r_d.st = WS_WAIT_DIR;
            end
            WS_WAIT_DIR: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        r_d.fault = 1'b1;
                        r_d.lvl   = FLVL_DIR;
                        r_d.ppn   = '0;
                        r_d.wr    = 1'b0;
                        r_d.usr   = 1'b0;
                        r_d.st    = WS_DONE;
                    end else begin
                        r_d.tbase = {ent_frame, {PAGE_BITS{1'b0}}};
                        r_d.st    = WS_READ_PTE;
                    end
                end
            end
            WS_READ_PTE: begin
                if (mem_req_ready) r_d.st = WS_WAIT_PTE;
            end
            WS_WAIT_PTE: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        r_d.fault = 1'b1;
                        r_d.lvl   = FLVL_TBL;
                        r_d.ppn   = '0;
                        r_d.wr    = 1'b0;
                        r_d.usr   = 1'b0;
                    end else begin
                        r_d.fault = 1'b0;
                        r_d.lvl   = FLVL_NONE;
                        r_d.ppn   = ent_frame;
                        r_d.wr    = ent_writable;
                        r_d.usr   = ent_user;
                    end
                    r_d.st = WS_DONE;
                end
            end
            WS_DONE: begin
                r_d.st = WS_IDLE;
            end
            default: begin
                r_d.st = WS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: WS_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready       = (r_q.st == WS_IDLE);
        mem_req_valid   = (r_q.st == WS_READ_DIR) || (r_q.st == WS_READ_PTE);
        mem_req_addr    = (r_q.st == WS_READ_PTE) ? pte_addr : dir_addr;
        res_valid       = (r_q.st == WS_DONE);
        res_fault       = r_q.fault;
        res_fault_level = r_q.lvl;
        res_ppn         = r_q.ppn;
        res_writable    = r_q.wr;
        res_user        = r_q.usr;
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int PPN_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              res_valid,
    input logic              res_fault,
    input logic [1:0]        res_fault_level,
    input logic [PPN_W-1:0]  res_ppn,
    input logic              res_writable,
    input logic              res_user
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            pend_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            pend_q <= 1'b0;
        end
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !mem_req_valid && !res_valid));

    p_fault_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_fault_level == 2'd1 || res_fault_level == 2'd2));

    p_fault_clears_ppn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_ppn == '0 && !res_writable && !res_user));

    p_ok_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> (res_fault_level == 2'd0));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || res_valid) |-> !req_ready);

    p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_ppn) && $stable(res_fault) && $stable(res_fault_level)
                        && $stable(res_writable) && $stable(res_user)));

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_req_valid);
endmodule

bind pt_walker pt_walker_chk #(
    .ADDR_W (ADDR_W),
    .PPN_W  (ADDR_W - PAGE_BITS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_ready       (req_ready),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .res_valid       (res_valid),
    .res_fault       (res_fault),
    .res_fault_level (res_fault_level),
    .res_ppn         (res_ppn),
    .res_writable    (res_writable),
    .res_user        (res_user)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_root = '0;
    logic [19:0] req_vpn = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_fault;
    logic [1:0]  res_fault_level;
    logic [19:0] res_ppn;
    logic        res_writable;
    logic        res_user;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    pt_walker u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_root        (req_root),
        .req_vpn         (req_vpn),
        .mem_req_valid   (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_req_addr    (mem_req_addr),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_data    (mem_rsp_data),
        .res_valid       (res_valid),
        .res_fault       (res_fault),
        .res_fault_level (res_fault_level),
        .res_ppn         (res_ppn),
        .res_writable    (res_writable),
        .res_user        (res_user)
    );

    // memory model: entry for read 0 and read 1 of a walk, configurable latency
    logic [31:0] mem_dent = '0;
    logic [31:0] mem_pte  = '0;
    logic [31:0] rd_addr [2];
    int          nrd = 0;
    int          lat = 0;
    int          cnt = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_data = '0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= pend_data;
                pend          <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (mem_req_valid && mem_req_ready) begin
            if (nrd < 2) rd_addr[nrd] <= mem_req_addr;
            pend_data <= (nrd == 0) ? mem_dent : mem_pte;
            pend      <= 1'b1;
            cnt       <= lat;
            nrd       <= nrd + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] root;
        logic [19:0] vpn;
        logic [31:0] dent;
        logic [31:0] pte;
        logic        fault;
        logic [1:0]  lvl;
        logic [19:0] ppn;
        logic        wr;
        logic        usr;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0010_0000, 20'h00000, 32'h0020_0001, 32'h1234_5007, 1'b0, 2'd0, 20'h12345, 1'b1, 1'b1},
        '{32'h0010_0000, 20'hFFFFF, 32'h0030_0003, 32'hABCD_E003, 1'b0, 2'd0, 20'hABCDE, 1'b1, 1'b0},
        '{32'h0040_0800, 20'h00401, 32'h0000_0000, 32'hFFFF_F007, 1'b1, 2'd1, 20'h00000, 1'b0, 1'b0},
        '{32'h0050_0000, 20'h12345, 32'h0060_0FFF, 32'h0000_0006, 1'b1, 2'd2, 20'h00000, 1'b0, 1'b0},
        '{32'h0070_0000, 20'h803FF, 32'hFFFF_F001, 32'hFFFF_F005, 1'b0, 2'd0, 20'hFFFFF, 1'b0, 1'b1},
        '{32'h0000_0000, 20'h2AAAA, 32'h0000_1FFE, 32'h5555_5007, 1'b1, 2'd1, 20'h00000, 1'b0, 1'b0}
    };

    // issue one walk and wait at negedges for the result strobe
    task automatic walk(input logic [31:0] root, input logic [19:0] vpn,
                        input logic [31:0] dent, input logic [31:0] pte);
        @(negedge clk);
        mem_dent  = dent;
        mem_pte   = pte;
        nrd       = 0;
        req_root  = root;
        req_vpn   = vpn;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (res_valid) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] exp_dir;
        logic [31:0] exp_pte;
        logic [19:0] held_ppn;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 req_ready in reset", {31'd0, req_ready}, 32'd1);
        chk("R1 mem_req_valid in reset", {31'd0, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 res_valid after reset", {31'd0, res_valid}, 32'd0);
        chk("R1 mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);

        // vector table: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            exp_dir = VECS[v].root + {20'd0, VECS[v].vpn[19:10], 2'b00};
            exp_pte = {VECS[v].dent[31:12], 12'h000} + {20'd0, VECS[v].vpn[9:0], 2'b00};
            walk(VECS[v].root, VECS[v].vpn, VECS[v].dent, VECS[v].pte);
            chk("R9 res_valid strobe", {31'd0, res_valid}, 32'd1);
            chk("R2 directory address", rd_addr[0], exp_dir);
            if (VECS[v].fault && VECS[v].lvl == 2'd1) begin
                chk("R3 single read", nrd, 32'd1);
            end else begin
                chk("R10 two reads", nrd, 32'd2);
                chk("R4 table address", rd_addr[1], exp_pte);
            end
            chk(VECS[v].fault ? (VECS[v].lvl == 2'd1 ? "R3 fault" : "R5 fault") : "R6 fault",
                {31'd0, res_fault}, {31'd0, VECS[v].fault});
            chk(VECS[v].fault ? (VECS[v].lvl == 2'd1 ? "R3 level" : "R5 level") : "R6 level",
                {30'd0, res_fault_level}, {30'd0, VECS[v].lvl});
            chk("R6 ppn", {12'd0, res_ppn}, {12'd0, VECS[v].ppn});
            chk("R6 flags", {30'd0, res_user, res_writable}, {30'd0, VECS[v].usr, VECS[v].wr});
            held_ppn = res_ppn;
            @(negedge clk);
            chk("R9 strobe one cycle", {31'd0, res_valid}, 32'd0);
            chk("R9 ppn held", {12'd0, res_ppn}, {12'd0, held_ppn});
        end

        // R7 / R10: stalled acceptance and slow response
        lat = 3;
        mem_ready_stall: begin
            exp_dir = 32'h0080_0000 + {20'd0, 10'h155, 2'b00};
            @(negedge clk);
            mem_dent = 32'h0090_0001;
            mem_pte  = 32'h0BEEF_003;
            nrd      = 0;
            mem_req_ready = 1'b0;
            req_root  = 32'h0080_0000;
            req_vpn   = {10'h155, 10'h2AA};
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk("R7 request held", {31'd0, mem_req_valid}, 32'd1);
                chk("R7 address stable", mem_req_addr, exp_dir);
                chk("R8 busy", {31'd0, req_ready}, 32'd0);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                chk("R10 no read while pending", {31'd0, mem_req_valid}, 32'd0);
                @(negedge clk);
            end
            // R8 / R9: a second request during the walk is ignored and the old result holds
            req_root  = 32'h0DEAD_000;
            req_vpn   = 20'h00000;
            req_valid = 1'b1;
            chk("R9 prior result held mid-walk", {12'd0, res_ppn}, {12'd0, held_ppn});
            for (int i = 0; i < 200; i++) begin
                if (res_valid) break;
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk("R8 ignored request: reads", nrd, 32'd2);
            chk("R8 ignored request: ppn", {12'd0, res_ppn}, 32'h0000_BEEF);
            chk("R7 dir address", rd_addr[0], exp_dir);
            chk("R4 table address", rd_addr[1], 32'h0090_0000 + {20'd0, 10'h2AA, 2'b00});
            @(negedge clk);
            chk("R8 ready after result", {31'd0, req_ready}, 32'd1);
            chk("R8 no extra read", nrd, 32'd2);
        end

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule